// File: doc/BRIEF.md
# Shadowed Channel Code Bank

This block holds the eight channel output codes of a multi-channel reference generator. Each channel has two copies of its code. A working copy drives the channel output. A backing copy stands in for a nonvolatile cell and survives a warm reset. After a warm reset, a load sequence copies every backing byte into its working register. While that runs, the `ready` output stays low. Once it finishes, the channel codes are valid.

A serial front end decodes the bus protocol and delivers transaction events: start, stop and abort, plus byte writes that carry an address. Written bytes are held in a small staging buffer and applied only when the stop arrives. A mode bit in the control register at address 08h selects what a commit does:
- **Mode 0:** a commit of channel bytes updates both copies. The block then reports busy for a programmable number of clock cycles, during which it ignores all bus traffic.
- **Mode 1:** a commit updates only the working copy.

The controller is a five-state machine:
- **LOAD:** runs the power-up copy, one channel per cycle. It moves to IDLE after the last channel.
- **IDLE:** waits for a start. A start moves it to COLLECT.
- **COLLECT:** accepts staged writes. An abort returns it to IDLE. A stop moves it to COMMIT. A repeated start stays in COLLECT and empties the buffer.
- **COMMIT:** applies the staged bytes in one cycle. It moves to PROGRAM when backing bytes must be written, otherwise to IDLE.
- **PROGRAM:** holds busy until the backing write completes, then returns to IDLE.

Top module: `gamma_shadow_bank`

## Requirements
- R1: After `rst_n` is released, `ready` is low for exactly NCH clock cycles while backing bytes are copied into the working registers. It then stays high, and `busy` is never high while `ready` is low.
- R2: The control register at address 08h reads 00h after a warm reset. Its bit 7 is the mode bit. Bits 6 to 0 always read 0, whatever value was written.
- R3: With mode 0, a committed write to address 00h–07h updates the working copy, and the value is still present after a warm reset reload.
- R4: With mode 1, a committed write to address 00h–07h updates the working copy only, does not raise `busy`, and is replaced by the backing value at the next warm reset.
- R5: `rd_data` returns the working copy for addresses 00h–07h, the control register for 08h, and 00h for every other address, independently of the mode bit.
- R6: Channel codes never change while bytes are being staged. A stop sampled on clock edge k makes the new codes visible after edge k+1.
- R7: A mode-0 commit that contains at least one channel byte raises `busy` after edge k+1 and holds it for exactly BUSY_CYCLES cycles. Start, stop, abort and write inputs are ignored for that whole time.
- R8: Writing the mode bit changes neither the working nor the backing copy of any channel.
- R9: After `nv_rst_n` (the factory default), every backing byte is 80h, so all channel codes are 80h after the load.
- R10: The staging buffer has four slots, and slot = address bits [1:0]. A later byte to the same slot replaces an earlier one. An abort, or a new start before a stop, discards every staged byte.
- R11: A write to address 08h takes effect at commit and never raises `busy`. The mode used by a commit is the mode in force before that commit.
- R12: Writes to addresses 09h–FFh are discarded at commit and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset; restarts the load sequence |
| nv_rst_n | input | 1 | Active-low factory reset of the backing copy to 80h |
| xfer_start | input | 1 | Pulse: start or repeated start addressed to this block |
| xfer_stop | input | 1 | Pulse: stop ending the transaction |
| xfer_abort | input | 1 | Pulse: transaction abandoned |
| wr_valid | input | 1 | Pulse: one data byte to stage |
| wr_addr | input | 8 | Register address of the staged byte |
| wr_data | input | 8 | Staged byte value |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| chan_code | output | NCH*8 | Working codes; channel i at bits [8i+7:8i] |
| busy | output | 1 | Backing copy being programmed |
| ready | output | 1 | Load sequence finished |

## Verification
Two conditions are hardest to reach from the ports:
- **Traffic during programming.** The stimulus starts a second complete transaction inside the busy window of a mode-0 commit. It then shows that the targeted channel kept its old code.
- **Which copy a commit wrote.** Outputs never show the backing copy directly. The bench therefore issues a warm reset after a mix of mode-0 and mode-1 commits and a mode toggle. The reloaded codes then show which commits reached the backing store.

Staging corners are covered by a multi-byte transaction with a replaced slot, by an abort, and by a repeated start.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] gsb_byte_t;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_PROGRAM
    } gsb_state_e;
endpackage

// File: rtl/gsb_stage.sv
// Staging buffer: one slot per low address bits, cleared per transaction.
module gsb_stage #(
    parameter int SLOTS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 wr_en,
    input  gsb_pkg::gsb_byte_t                   wr_addr,
    input  gsb_pkg::gsb_byte_t                   wr_data,
    output logic [SLOTS-1:0]                     slot_valid,
    output logic [SLOTS-1:0][gsb_pkg::BYTE_W-1:0] slot_addr,
    output logic [SLOTS-1:0][gsb_pkg::BYTE_W-1:0] slot_data
);
    localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_addr[SW-1:0] == SW'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_valid[s] <= 1'b0;
                slot_addr[s]  <= '0;
                slot_data[s]  <= '0;
            end else if (clear) begin
                slot_valid[s] <= 1'b0;
            end else if (hit) begin
                slot_valid[s] <= 1'b1;
                slot_addr[s]  <= wr_addr;
                slot_data[s]  <= wr_data;
            end
        end
    end
endmodule

// File: rtl/gsb_nvstore.sv
// Backing store with emulated programming delay.
module gsb_nvstore #(
    parameter int              NCH         = 8,
    parameter int              BUSY_CYCLES = 1_000_000,
    parameter logic [7:0]      NV_DEFAULT  = 8'h80
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                nv_rst_n,
    input  logic                                go,
    input  logic [NCH-1:0]                      go_mask,
    input  logic [NCH-1:0][gsb_pkg::BYTE_W-1:0] go_data,
    output logic [NCH-1:0][gsb_pkg::BYTE_W-1:0] nv_vec,
    output logic                                done
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES - 1);

    logic                                active_q;
    logic [CW-1:0]                       cnt_q;
    logic [NCH-1:0]                      mask_q;
    logic [NCH-1:0][gsb_pkg::BYTE_W-1:0] data_q;

    assign done = active_q && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            mask_q   <= '0;
            data_q   <= '0;
        end else if (go) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            mask_q   <= go_mask;
            data_q   <= go_data;
        end else if (done) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cell
        always_ff @(posedge clk or negedge nv_rst_n) begin
            if (!nv_rst_n) begin
                nv_vec[i] <= NV_DEFAULT;
            end else if (done && mask_q[i]) begin
                nv_vec[i] <= data_q[i];
            end
        end
    end
endmodule

// File: rtl/gsb_fsm.sv
// Sequencing: load, collect, commit, program.
module gsb_fsm #(
    parameter int NCH = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            xfer_start,
    input  logic                            xfer_stop,
    input  logic                            xfer_abort,
    input  logic                            need_nv,
    input  logic                            nv_done,
    output logic                            load_en,
    output logic [$clog2(NCH)-1:0]          load_idx,
    output logic                            stage_clear,
    output logic                            stage_open,
    output logic                            commit_stb,
    output logic                            busy,
    output logic                            ready
);
    import gsb_pkg::*;

    localparam int IW = $clog2(NCH);
    localparam logic [IW-1:0] IDX_LAST = IW'(NCH - 1);

    gsb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_idx <= '0;
        end else if (state_q == ST_LOAD) begin
            load_idx <= load_idx + 1'b1;
        end else begin
            load_idx <= '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:    if (load_idx == IDX_LAST) state_d = ST_IDLE;
            ST_IDLE:    if (xfer_start) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (xfer_abort)     state_d = ST_IDLE;
                else if (xfer_stop) state_d = ST_COMMIT;
                else                state_d = ST_COLLECT;
            end
            ST_COMMIT:  state_d = need_nv ? ST_PROGRAM : ST_IDLE;
            ST_PROGRAM: if (nv_done) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en     = 1'b0;
        stage_clear = 1'b0;
        stage_open  = 1'b0;
        commit_stb  = 1'b0;
        busy        = 1'b0;
        ready       = 1'b1;
        unique case (state_q)
            ST_LOAD: begin
                load_en = 1'b1;
                ready   = 1'b0;
            end
            ST_IDLE:    stage_clear = xfer_start;
            ST_COLLECT: begin
                stage_open  = !(xfer_abort || xfer_stop);
                stage_clear = xfer_abort || (!xfer_stop && xfer_start);
            end
            ST_COMMIT: begin
                commit_stb  = 1'b1;
                stage_clear = 1'b1;
            end
            ST_PROGRAM: busy = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/gamma_shadow_bank.sv
// Channel code bank with working and backing copies.
module gamma_shadow_bank #(
    parameter int         NCH         = 8,
    parameter int         SLOTS       = 4,
    parameter int         BUSY_CYCLES = 1_000_000,
    parameter logic [7:0] NV_DEFAULT  = 8'h80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nv_rst_n,
    input  logic               xfer_start,
    input  logic               xfer_stop,
    input  logic               xfer_abort,
    input  logic               wr_valid,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_addr,
    output logic [7:0]         rd_data,
    output logic [NCH*8-1:0]   chan_code,
    output logic               busy,
    output logic               ready
);
    import gsb_pkg::*;

    localparam int        IW        = $clog2(NCH);
    localparam gsb_byte_t CTRL_ADDR = BYTE_W'(NCH);

    logic                       load_en, stage_clear, stage_open, commit_stb;
    logic [IW-1:0]              load_idx;
    logic                       nv_done, need_nv;
    logic [SLOTS-1:0]           slot_valid;
    logic [SLOTS-1:0][BYTE_W-1:0] slot_addr, slot_data;
    logic [NCH-1:0][BYTE_W-1:0] nv_vec, work_q, c_data;
    logic [NCH-1:0]             c_mask;
    logic                       c_ctrl_hit, c_ctrl_val;
    logic                       mode_q;

    gsb_fsm #(.NCH(NCH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_stop  (xfer_stop),
        .xfer_abort (xfer_abort),
        .need_nv    (need_nv),
        .nv_done    (nv_done),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .stage_clear(stage_clear),
        .stage_open (stage_open),
        .commit_stb (commit_stb),
        .busy       (busy),
        .ready      (ready)
    );

    gsb_stage #(.SLOTS(SLOTS)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (stage_clear),
        .wr_en     (wr_valid && stage_open),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .slot_valid(slot_valid),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    gsb_nvstore #(
        .NCH        (NCH),
        .BUSY_CYCLES(BUSY_CYCLES),
        .NV_DEFAULT (NV_DEFAULT)
    ) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_rst_n(nv_rst_n),
        .go      (commit_stb && need_nv),
        .go_mask (c_mask),
        .go_data (c_data),
        .nv_vec  (nv_vec),
        .done    (nv_done)
    );

    // Decode staged slots into per-channel writes and a control write.
    always_comb begin
        c_mask     = '0;
        c_data     = '0;
        c_ctrl_hit = 1'b0;
        c_ctrl_val = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (slot_valid[s]) begin
                if (slot_addr[s] < CTRL_ADDR) begin
                    c_mask[slot_addr[s][IW-1:0]] = 1'b1;
                    c_data[slot_addr[s][IW-1:0]] = slot_data[s];
                end else if (slot_addr[s] == CTRL_ADDR) begin
                    c_ctrl_hit = 1'b1;
                    c_ctrl_val = slot_data[s][BYTE_W-1];
                end
            end
        end
    end

    assign need_nv = !mode_q && (|c_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (commit_stb && c_ctrl_hit) begin
            mode_q <= c_ctrl_val;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_work
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                work_q[i] <= '0;
            end else if (load_en && (load_idx == IW'(i))) begin
                work_q[i] <= nv_vec[i];
            end else if (commit_stb && c_mask[i]) begin
                work_q[i] <= c_data[i];
            end
        end
        assign chan_code[i*BYTE_W +: BYTE_W] = work_q[i];
    end

    always_comb begin
        if (rd_addr < CTRL_ADDR) begin
            rd_data = work_q[rd_addr[IW-1:0]];
        end else if (rd_addr == CTRL_ADDR) begin
            rd_data = {mode_q, {(BYTE_W-1){1'b0}}};
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/gamma_shadow_bank_chk.sv
// Port-level properties, bound to the top module.
module gamma_shadow_bank_chk #(
    parameter int NCH         = 8,
    parameter int BUSY_CYCLES = 1_000_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_stop,
    input logic [7:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic [NCH*8-1:0] chan_code,
    input logic             busy,
    input logic             ready
);
    logic [31:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy ? busy_cnt + 32'd1 : 32'd0;
    end

    p_busy_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 32'(BUSY_CYCLES)));

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == 32'(BUSY_CYCLES)));

    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> ready);

    p_no_busy_loading_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !busy);

    p_codes_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready) && !$past(xfer_stop, 2)) |-> $stable(chan_code));

    p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'(NCH)) |-> (rd_data[6:0] == 7'd0));

    p_read_unmapped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > 8'(NCH)) |-> (rd_data == 8'd0));
endmodule

bind gamma_shadow_bank gamma_shadow_bank_chk #(
    .NCH        (NCH),
    .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer_stop(xfer_stop),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .chan_code(chan_code),
    .busy     (busy),
    .ready    (ready)
);

// File: tb/gamma_shadow_bank_tb.sv
module gamma_shadow_bank_tb;
    localparam int NCH = 8;
    localparam int BC  = 40;
    localparam int NV  = 6;
    // {write addr, write data, read addr, expected read}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'h3C, 8'h00, 8'h3C},
        {8'h07, 8'hC5, 8'h07, 8'hC5},
        {8'h03, 8'h00, 8'h03, 8'h00},
        {8'h04, 8'hFF, 8'h04, 8'hFF},
        {8'h0A, 8'h55, 8'h0A, 8'h00},
        {8'h08, 8'h7F, 8'h08, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, nv_rst_n = 1'b0;
    logic xfer_start = 1'b0, xfer_stop = 1'b0, xfer_abort = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic [NCH*8-1:0] chan_code;
    logic busy, ready;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    gamma_shadow_bank #(.NCH(NCH), .SLOTS(4), .BUSY_CYCLES(BC), .NV_DEFAULT(8'h80)) u_dut (
        .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n),
        .xfer_start(xfer_start), .xfer_stop(xfer_stop), .xfer_abort(xfer_abort),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .chan_code(chan_code),
        .busy(busy), .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] code(input int ch);
        return chan_code[ch*8 +: 8];
    endfunction

    task automatic pulse_start();
        @(negedge clk) xfer_start = 1'b1;
        @(negedge clk) xfer_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk) xfer_stop = 1'b1;
        @(negedge clk) xfer_stop = 1'b0;
    endtask
    task automatic pulse_abort();
        @(negedge clk) xfer_abort = 1'b1;
        @(negedge clk) xfer_abort = 1'b0;
    endtask
    task automatic put(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk) begin wr_valid = 1'b1; wr_addr = a; wr_data = d; end
        @(negedge clk) wr_valid = 1'b0;
    endtask
    // Count busy cycles following a commit; ends one negedge after commit edge.
    task automatic settle(output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask
    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask
    task automatic warm_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 chk("R1 ready low during load", int'(ready), 0);
        repeat (NCH - 1) @(negedge clk);
        chk("R1 ready still low at last load cycle", int'(ready), 0);
        @(negedge clk);
        chk("R1 ready high after NCH cycles", int'(ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        nv_rst_n = 1'b1;
        warm_reset();
        // R9: factory default loaded into every channel
        for (int i = 0; i < NCH; i++) chk("R9 default code", int'(code(i)), 8'h80);
        rd(8'h08, v); chk("R2 control reads 00h after reset", int'(v), 0);
        chk("R7 not busy after load", int'(busy), 0);

        // Table walk: single-byte transactions in mode 0
        for (int k = 0; k < NV; k++) begin
            logic [7:0] wa, wd, ra, ex;
            {wa, wd, ra, ex} = VEC[k];
            pulse_start();
            put(wa, wd);
            pulse_stop();
            settle(n);
            chk("R7/R11/R12 busy length", n, (wa < 8'h08) ? BC : 0);
            rd(ra, v);
            chk("R3/R5/R2/R12 read after commit", int'(v), int'(ex));
        end
        rd(8'h05, v); chk("R5 read returns working copy", int'(v), int'(code(5)));
        rd(8'hFF, v); chk("R5 unmapped address reads 0", int'(v), 0);

        // Multi-byte with replaced slot; codes held until stop
        pulse_start();
        put(8'h04, 8'hA1);
        put(8'h05, 8'hB2);
        put(8'h04, 8'hC3);
        put(8'h06, 8'hD4);
        chk("R6 no change before stop", int'(code(4)), 8'hFF);
        @(negedge clk) xfer_stop = 1'b1;
        @(negedge clk) xfer_stop = 1'b0;
        chk("R6 unchanged in commit cycle", int'(code(5)), 8'h80);
        settle(n);
        chk("R7 multi-byte busy length", n, BC);
        chk("R10 replaced slot", int'(code(4)), 8'hC3);
        chk("R10 second slot", int'(code(5)), 8'hB2);
        chk("R10 third slot", int'(code(6)), 8'hD4);
        chk("R10 untouched channel", int'(code(7)), 8'hC5);

        // Abort discards
        pulse_start();
        put(8'h01, 8'h99);
        pulse_abort();
        repeat (3) @(negedge clk);
        chk("R10 abort discards", int'(code(1)), 8'h80);
        chk("R10 abort no busy", int'(busy), 0);

        // Repeated start discards earlier bytes
        pulse_start();
        put(8'h02, 8'h77);
        pulse_start();
        put(8'h03, 8'h66);
        pulse_stop();
        settle(n);
        chk("R10 restart discards", int'(code(2)), 8'h80);
        chk("R10 restart keeps later", int'(code(3)), 8'h66);

        // Traffic during busy is ignored
        pulse_start();
        put(8'h00, 8'h5A);
        pulse_stop();
        @(negedge clk);
        chk("R7 busy after commit", int'(busy), 1);
        pulse_start();
        put(8'h01, 8'h12);
        pulse_stop();
        chk("R7 still busy", int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R7 write during busy ignored", int'(code(1)), 8'h80);
        chk("R3 mode0 working updated", int'(code(0)), 8'h5A);

        // Mode 1: working copy only
        pulse_start(); put(8'h08, 8'h80); pulse_stop(); settle(n);
        chk("R11 control write no busy", n, 0);
        rd(8'h08, v); chk("R11 mode bit set at commit", int'(v), 8'h80);
        pulse_start(); put(8'h02, 8'h11); pulse_stop(); settle(n);
        chk("R4 mode1 no busy", n, 0);
        chk("R4 mode1 working updated", int'(code(2)), 8'h11);
        pulse_start(); put(8'h08, 8'h00); pulse_stop(); settle(n);
        chk("R8 mode toggle keeps code", int'(code(2)), 8'h11);
        chk("R8 mode toggle no busy", n, 0);
        rd(8'h02, v); chk("R5 read in mode change", int'(v), 8'h11);

        // Warm reset: reload reveals backing contents
        warm_reset();
        rd(8'h08, v); chk("R2 control cleared by warm reset", int'(v), 0);
        chk("R4 mode1 write not in backing", int'(code(2)), 8'h80);
        chk("R3 mode0 write kept", int'(code(0)), 8'h5A);
        chk("R3 multi-byte kept", int'(code(4)), 8'hC3);
        chk("R8 backing unchanged by toggle", int'(code(3)), 8'h66);
        chk("R7 ignored write not in backing", int'(code(1)), 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule